// File: doc/BRIEF.md
# Host Configuration Address/Data Port

This block gives a CPU access to the configuration space of devices behind a host bridge through two registers: an address register that selects the configuration target and a data window that performs the access. The CPU writes a configuration address, then reads or writes the data window. When the address register's enable bit is set, the block forwards the access to a configuration target over a valid/ready request channel. For reads it then waits for a response strobe. When the enable bit is clear, a data write is dropped and a data read returns all ones. In both cases no request is issued.

Two byte-order layers sit on the path. A bit in the host control register selects the byte order of all CPU-side register traffic: when that bit is clear, write data is byte-reversed before decode and read data is byte-reversed after decode. The second layer applies only to the data window. Forwarded data is byte-reversed in both directions when bit 0 of the command register is clear and the bus/device field of the stored address is non-zero.

The CPU side uses a simple request/acknowledge handshake. The CPU holds `cpu_req` until it sees a one-cycle `cpu_ack`, so a forwarded access stalls the CPU until the target completes it. Only full 32-bit words are transferred.

Top module: `cfgport_host`

## Requirements
- R1: After reset the host control register reads 0x00001000, the command register reads 0x00010001 and the configuration address register reads 0. `cfg_req_valid` and `cpu_ack` are low while reset is held.
- R2: A write to the configuration address register (word offset 2) stores the logical value ANDed with 0x80FFFFFC, and a read returns the stored value. Bit 31 is the enable bit. Every forwarded request carries this stored value, with bit 31 set and the masked bits zero.
- R3: A write to the command register (word offset 1) stores the logical value ANDed with 0x0401FC0F, and a read returns the stored value.
- R4: A read of the data window (word offset 3) while the enable bit is clear returns 0xFFFFFFFF and issues no request.
- R5: A write to the data window while the enable bit is clear is dropped without a request and is still acknowledged.
- R6: A data-window access with the enable bit set raises `cfg_req_valid` with the stored address, the write flag and the data. These are held stable until `cfg_req_ready`. A write is acknowledged in the cycle after the handshake.
- R7: A forwarded read is acknowledged only in the cycle after `cfg_rsp_valid`, and it returns the response data. It completes 3 + (ready wait) + (response wait) cycles after the request is driven.
- R8: Data-window data is byte-reversed in both directions when command bit 0 is 0 and address bits [23:11] are not all zero. Otherwise it passes unchanged.
- R9: When host control bit 12 is 0, every CPU write value is byte-reversed before decode and every CPU read value after decode. When the bit is 1, nothing is reversed. The host control register is word offset 0 and stores its full logical value.
- R10: Each accepted access gives exactly one one-cycle `cpu_ack`. No new access is accepted in the ack cycle, and no request is pending while `cpu_ack` is high.
- R11: Word offsets 4 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word offset of the register |
| cpu_wdata | input | 32 | CPU write data (bus byte order) |
| cpu_ack | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_ready | input | 1 | Target accepts the request |
| cfg_req_addr | output | 32 | Stored configuration address |
| cfg_req_write | output | 1 | Request is a write |
| cfg_req_wdata | output | 32 | Write data toward the target |
| cfg_rsp_valid | input | 1 | Read response strobe |
| cfg_rsp_data | input | 32 | Read response data |

## Verification
The bench builds the block with its defaults: a 4-bit word offset, the four registers at offsets 0 to 3, and reset values 0x00001000 and 0x00010001. This leaves twelve unused offsets, which are swept in full. The main sweep covers every combination of host byte order, command order bit, four bus/device field patterns (zero, lowest bit, highest bit, mixed) and the enable bit. For each combination it does address write/readback plus a data write and a data read. Ready and response waits of 0 to 2 cycles rotate across the sweep, so exact completion latencies are checked arithmetically.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = WORD_W / BYTE_W;

  localparam logic [WORD_W-1:0] CADDR_MASK = 32'h80FF_FFFC;
  localparam logic [WORD_W-1:0] CMD_MASK   = 32'h0401_FC0F;
  localparam logic [WORD_W-1:0] READ_IDLE  = 32'hFFFF_FFFF;

  localparam int unsigned CADDR_EN_BIT   = 31;
  localparam int unsigned DEV_LO         = 11;
  localparam int unsigned DEV_HI         = 23;
  localparam int unsigned HOST_ORDER_BIT = 12;
  localparam int unsigned CMD_ORDER_BIT  = 0;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/cfgport_rst_sync.sv
module cfgport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfgport_swap.sv
module cfgport_swap #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                      en,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout
);
  logic [LANES*LANE_W-1:0] rev;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rev[i*LANE_W +: LANE_W] = din[(LANES-1-i)*LANE_W +: LANE_W];
  end

  assign dout = en ? rev : din;
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
  import cfgport_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 4,
  parameter logic [ADDR_W-1:0]  HOSTCTL_OFF = 'd0,
  parameter logic [ADDR_W-1:0]  CMD_OFF     = 'd1,
  parameter logic [ADDR_W-1:0]  CADDR_OFF   = 'd2,
  parameter logic [WORD_W-1:0]  HOSTCTL_RST = 32'h0000_1000,
  parameter logic [WORD_W-1:0]  CMD_RST     = 32'h0001_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              host_order,
  output logic              cmd_order,
  output logic [WORD_W-1:0] caddr
);
  logic [WORD_W-1:0] host_q, host_d;
  logic [WORD_W-1:0] cmd_q, cmd_d;
  logic [WORD_W-1:0] caddr_q, caddr_d;
  logic              host_ce, cmd_ce, caddr_ce;

  always_comb begin
    host_ce  = wr_en && (wr_addr == HOSTCTL_OFF);
    cmd_ce   = wr_en && (wr_addr == CMD_OFF);
    caddr_ce = wr_en && (wr_addr == CADDR_OFF);
    host_d   = wr_data;
    cmd_d    = wr_data & CMD_MASK;
    caddr_d  = wr_data & CADDR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q  <= HOSTCTL_RST;
      cmd_q   <= CMD_RST & CMD_MASK;
      caddr_q <= '0;
    end else begin
      if (host_ce)  host_q  <= host_d;
      if (cmd_ce)   cmd_q   <= cmd_d;
      if (caddr_ce) caddr_q <= caddr_d;
    end
  end

  always_comb begin
    case (rd_addr)
      HOSTCTL_OFF: rd_data = host_q;
      CMD_OFF:     rd_data = cmd_q;
      CADDR_OFF:   rd_data = caddr_q;
      default:     rd_data = '0;
    endcase
  end

  assign host_order = host_q[HOST_ORDER_BIT];
  assign cmd_order  = cmd_q[CMD_ORDER_BIT];
  assign caddr      = caddr_q;
endmodule

// File: rtl/cfgport_seq.sv
module cfgport_seq
  import cfgport_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CDATA_OFF = 'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] fwd_wdata,
  input  logic [WORD_W-1:0] loc_rdata,
  input  logic [WORD_W-1:0] rsp_rdata,
  input  logic              window_en,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              reg_wr_en,
  output logic              req_valid,
  output logic              req_write,
  output logic [WORD_W-1:0] req_wdata,
  output logic              cpu_ack,
  output logic [WORD_W-1:0] cpu_rdata
);
  sq_state_e         state_q, state_d;
  logic              ack_q, ack_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              rdata_ce;
  logic              write_q, write_d;
  logic [WORD_W-1:0] wdat_q, wdat_d;
  logic              launch;
  logic              accept, is_window;

  always_comb begin
    accept    = cpu_req && !ack_q && (state_q == SQ_IDLE);
    is_window = (cpu_addr == CDATA_OFF);
    reg_wr_en = accept && cpu_we && !is_window;

    state_d  = state_q;
    ack_d    = 1'b0;
    rdata_d  = rdata_q;
    rdata_ce = 1'b0;
    write_d  = cpu_we;
    wdat_d   = fwd_wdata;
    launch   = 1'b0;

    case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          if (is_window && window_en) begin
            launch  = 1'b1;
            state_d = SQ_ISSUE;
          end else begin
            ack_d    = 1'b1;
            rdata_ce = 1'b1;
            if (cpu_we)         rdata_d = '0;
            else if (is_window) rdata_d = READ_IDLE;
            else                rdata_d = loc_rdata;
          end
        end
      end
      SQ_ISSUE: begin
        if (req_ready) begin
          if (write_q) begin
            ack_d    = 1'b1;
            rdata_ce = 1'b1;
            rdata_d  = '0;
            state_d  = SQ_IDLE;
          end else begin
            state_d = SQ_WAIT;
          end
        end
      end
      SQ_WAIT: begin
        if (rsp_valid) begin
          ack_d    = 1'b1;
          rdata_ce = 1'b1;
          rdata_d  = rsp_rdata;
          state_d  = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      write_q <= 1'b0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      if (rdata_ce) rdata_q <= rdata_d;
      if (launch) begin
        write_q <= write_d;
        wdat_q  <= wdat_d;
      end
    end
  end

  assign req_valid = (state_q == SQ_ISSUE);
  assign req_write = write_q;
  assign req_wdata = wdat_q;
  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
endmodule

// File: rtl/cfgport_host.sv
module cfgport_host
  import cfgport_pkg::*;
#(
  parameter int unsigned        ADDR_W      = 4,
  parameter logic [ADDR_W-1:0]  HOSTCTL_OFF = 'd0,
  parameter logic [ADDR_W-1:0]  CMD_OFF     = 'd1,
  parameter logic [ADDR_W-1:0]  CADDR_OFF   = 'd2,
  parameter logic [ADDR_W-1:0]  CDATA_OFF   = 'd3,
  parameter logic [31:0]        HOSTCTL_RST = 32'h0000_1000,
  parameter logic [31:0]        CMD_RST     = 32'h0001_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ack,
  output logic [31:0]       cpu_rdata,
  output logic              cfg_req_valid,
  input  logic              cfg_req_ready,
  output logic [31:0]       cfg_req_addr,
  output logic              cfg_req_write,
  output logic [31:0]       cfg_req_wdata,
  input  logic              cfg_rsp_valid,
  input  logic [31:0]       cfg_rsp_data
);
  logic              rst_sync_n;
  logic              host_order, cmd_order;
  logic              host_swap, data_swap;
  logic [WORD_W-1:0] caddr;
  logic [WORD_W-1:0] wr_logical, fwd_wdata;
  logic [WORD_W-1:0] reg_rdata, loc_bus;
  logic [WORD_W-1:0] rsp_logical, rsp_bus;
  logic              reg_wr_en;

  cfgport_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign host_swap = !host_order;
  assign data_swap = !cmd_order && (caddr[DEV_HI:DEV_LO] != '0);

  // CPU-side order layer on incoming data, ahead of decode (R9)
  cfgport_swap #(.LANES(LANES), .LANE_W(BYTE_W)) u_sw_cpu_in (
    .en(host_swap), .din(cpu_wdata), .dout(wr_logical)
  );
  // window order layer toward the target (R8)
  cfgport_swap #(.LANES(LANES), .LANE_W(BYTE_W)) u_sw_cfg_out (
    .en(data_swap), .din(wr_logical), .dout(fwd_wdata)
  );
  // window order layer on the response (R8)
  cfgport_swap #(.LANES(LANES), .LANE_W(BYTE_W)) u_sw_cfg_in (
    .en(data_swap), .din(cfg_rsp_data), .dout(rsp_logical)
  );
  // CPU-side order layer after decode, local registers and responses (R9)
  cfgport_swap #(.LANES(LANES), .LANE_W(BYTE_W)) u_sw_cpu_loc (
    .en(host_swap), .din(reg_rdata), .dout(loc_bus)
  );
  cfgport_swap #(.LANES(LANES), .LANE_W(BYTE_W)) u_sw_cpu_rsp (
    .en(host_swap), .din(rsp_logical), .dout(rsp_bus)
  );

  cfgport_regs #(
    .ADDR_W(ADDR_W), .HOSTCTL_OFF(HOSTCTL_OFF), .CMD_OFF(CMD_OFF),
    .CADDR_OFF(CADDR_OFF), .HOSTCTL_RST(HOSTCTL_RST), .CMD_RST(CMD_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(reg_wr_en), .wr_addr(cpu_addr), .wr_data(wr_logical),
    .rd_addr(cpu_addr), .rd_data(reg_rdata),
    .host_order(host_order), .cmd_order(cmd_order), .caddr(caddr)
  );

  cfgport_seq #(.ADDR_W(ADDR_W), .CDATA_OFF(CDATA_OFF)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .fwd_wdata(fwd_wdata), .loc_rdata(loc_bus), .rsp_rdata(rsp_bus),
    .window_en(caddr[CADDR_EN_BIT]),
    .req_ready(cfg_req_ready), .rsp_valid(cfg_rsp_valid),
    .reg_wr_en(reg_wr_en),
    .req_valid(cfg_req_valid), .req_write(cfg_req_write), .req_wdata(cfg_req_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata)
  );

  assign cfg_req_addr = caddr;
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker
  import cfgport_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_ack,
  input logic        cfg_req_valid,
  input logic        cfg_req_ready,
  input logic [31:0] cfg_req_addr,
  input logic        cfg_req_write,
  input logic [31:0] cfg_req_wdata
);
  // R2: every issued request carries an enabled, masked address
  a_r2_req_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_valid |-> (((cfg_req_addr & ~CADDR_MASK) == 32'h0) && cfg_req_addr[CADDR_EN_BIT]));

  // R6: request fields hold while the target is not ready
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && !cfg_req_ready) |=>
      (cfg_req_valid && $stable(cfg_req_addr) && $stable(cfg_req_write) && $stable(cfg_req_wdata)));

  // R6: a forwarded write is acknowledged right after its handshake
  a_r6_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && cfg_req_ready && cfg_req_write) |=> cpu_ack);

  // R7: a forwarded read never completes at its handshake
  a_r7_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_valid && cfg_req_ready && !cfg_req_write) |=> !cpu_ack);

  // R10: acknowledge is a single-cycle pulse
  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R10: nothing pending toward the target while acknowledging
  a_r10_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> !cfg_req_valid);
endmodule

bind cfgport_host cfgport_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_ack(cpu_ack),
  .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
  .cfg_req_addr(cfg_req_addr), .cfg_req_write(cfg_req_write),
  .cfg_req_wdata(cfg_req_wdata)
);

// File: tb/sim_cfgport_host.sv
`timescale 1ns/1ps
module sim_cfgport_host;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [3:0]  cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        cfg_req_valid, cfg_req_ready, cfg_req_write;
  logic [31:0] cfg_req_addr, cfg_req_wdata;
  logic        cfg_rsp_valid;
  logic [31:0] cfg_rsp_data;

  int checks = 0;
  int errors = 0;
  int n_hs = 0;
  int tgt_delay = 0;
  int rsp_delay = 0;
  logic [31:0] last_addr, last_wdata;
  logic        last_write;
  bit          cur_swap = 1'b0;

  always #2.5 clk = ~clk;

  cfgport_host u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .cfg_req_valid(cfg_req_valid), .cfg_req_ready(cfg_req_ready),
    .cfg_req_addr(cfg_req_addr), .cfg_req_write(cfg_req_write),
    .cfg_req_wdata(cfg_req_wdata),
    .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data)
  );

  function automatic logic [31:0] bsw(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction
  function automatic logic [31:0] hsw(input logic [31:0] x);
    return cur_swap ? bsw(x) : x;
  endfunction
  function automatic logic [31:0] tgt(input logic [31:0] a);
    return a ^ 32'h5A3C_0F96;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] r, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ack);
    r = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  // configuration target model
  initial begin
    cfg_req_ready = 1'b0; cfg_rsp_valid = 1'b0; cfg_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (cfg_req_valid) begin
        repeat (tgt_delay) @(negedge clk);
        cfg_req_ready = 1'b1;
        last_addr = cfg_req_addr; last_write = cfg_req_write; last_wdata = cfg_req_wdata;
        n_hs++;
        @(negedge clk);
        cfg_req_ready = 1'b0;
        if (!last_write) begin
          repeat (rsp_delay) @(negedge clk);
          cfg_rsp_valid = 1'b1; cfg_rsp_data = tgt(last_addr);
          @(negedge clk);
          cfg_rsp_valid = 1'b0; cfg_rsp_data = '0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int cyc;
    int n0;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R1 req_valid in reset", {31'b0, cfg_req_valid}, 32'h0);
    chk("R1 ack in reset", {31'b0, cpu_ack}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    acc(1'b0, 4'd0, 32'h0, r, cyc); chk("R1 host ctl reset", r, 32'h0000_1000);
    acc(1'b0, 4'd1, 32'h0, r, cyc); chk("R1 command reset", r, 32'h0001_0001);
    acc(1'b0, 4'd2, 32'h0, r, cyc); chk("R1 address reset", r, 32'h0);
    chk("R10 local latency", cyc, 1);

    // R11: unused offsets
    for (int a = 4; a < 16; a++) begin
      acc(1'b1, 4'(a), 32'hDEAD_0000 | 32'(a), r, cyc);
      acc(1'b0, 4'(a), 32'h0, r, cyc);
      chk("R11 unused offset reads zero", r, 32'h0);
    end
    acc(1'b0, 4'd0, 32'h0, r, cyc); chk("R11 host ctl untouched", r, 32'h0000_1000);
    acc(1'b0, 4'd1, 32'h0, r, cyc); chk("R11 command untouched", r, 32'h0001_0001);
    acc(1'b0, 4'd2, 32'h0, r, cyc); chk("R11 address untouched", r, 32'h0);

    // R3: command mask
    acc(1'b1, 4'd1, 32'hFFFF_FFFF, r, cyc);
    acc(1'b0, 4'd1, 32'h0, r, cyc); chk("R3 command mask ones", r, 32'h0401_FC0F);
    acc(1'b1, 4'd1, 32'h0, r, cyc);
    acc(1'b0, 4'd1, 32'h0, r, cyc); chk("R3 command zero", r, 32'h0);

    for (int h = 0; h < 2; h++) begin
      logic [31:0] hl;
      hl = (32'(h) << 12) | 32'h0000_0A50;
      acc(1'b1, 4'd0, hsw(hl), r, cyc);
      cur_swap = (h == 0);
      acc(1'b0, 4'd0, 32'h0, r, cyc);
      chk("R9 host ctl readback", r, hsw(hl));
      for (int c = 0; c < 2; c++) begin
        logic [31:0] cl;
        cl = 32'hFFFF_FFFE | 32'(c);
        acc(1'b1, 4'd1, hsw(cl), r, cyc);
        acc(1'b0, 4'd1, 32'h0, r, cyc);
        chk("R3 R9 command readback", r, hsw(cl & 32'h0401_FC0F));
        for (int di = 0; di < 4; di++) begin
          logic [31:0] dev;
          case (di)
            0: dev = 32'h0;
            1: dev = 32'h0000_0800;
            2: dev = 32'h0080_0000;
            default: dev = 32'h0A5A << 11;
          endcase
          for (int e = 0; e < 2; e++) begin
            logic [31:0] al, ea, w, exp_r;
            bit ds;
            al = (32'(e) << 31) | 32'h7F00_0000 | dev | 32'h0000_0503 | (32'(di) << 4);
            ea = al & 32'h80FF_FFFC;
            acc(1'b1, 4'd2, hsw(al), r, cyc);
            acc(1'b0, 4'd2, 32'h0, r, cyc);
            chk("R2 address masked readback", r, hsw(ea));
            tgt_delay = (h + c + di) % 3;
            rsp_delay = (di + e) % 3;
            ds = (c == 0) && (dev != 0);
            w = 32'h1122_3344 + 32'(di) * 32'h0101_0101 + 32'(e) + (32'(c) << 20) + (32'(h) << 28);
            n0 = n_hs;
            acc(1'b1, 4'd3, hsw(w), r, cyc);
            if (e == 1) begin
              chk("R6 write forwarded", 32'(n_hs - n0), 32'd1);
              chk("R6 write addr", last_addr, ea);
              chk("R6 write flag", {31'b0, last_write}, 32'h1);
              chk("R8 write data order", last_wdata, ds ? bsw(w) : w);
              chk("R6 write latency", 32'(cyc), 32'(2 + tgt_delay));
            end else begin
              chk("R5 disabled write dropped", 32'(n_hs - n0), 32'd0);
              chk("R5 disabled write latency", 32'(cyc), 32'd1);
            end
            n0 = n_hs;
            acc(1'b0, 4'd3, 32'h0, r, cyc);
            if (e == 1) begin
              exp_r = ds ? bsw(tgt(ea)) : tgt(ea);
              chk("R7 R8 R9 read data", r, hsw(exp_r));
              chk("R7 read forwarded", 32'(n_hs - n0), 32'd1);
              chk("R7 read flag", {31'b0, last_write}, 32'h0);
              chk("R7 read latency", 32'(cyc), 32'(3 + tgt_delay + rsp_delay));
            end else begin
              chk("R4 disabled read all ones", r, 32'hFFFF_FFFF);
              chk("R4 disabled read no request", 32'(n_hs - n0), 32'd0);
            end
            @(negedge clk);
            chk("R10 ack single cycle", {31'b0, cpu_ack}, 32'h0);
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule